// File: doc/BRIEF.md
# Three-Channel Prescaled Reload Timer

This block holds three independent 32-bit down-counters. Each one runs from the core clock through its own prescaler, which divides by 16, 64, 256, 1024 or 4096. A single start register carries one run bit per channel. While its run bit is set, a channel's counter steps down by one on every prescaled tick. When a tick finds the counter at zero, the counter reloads from the channel's constant register and a sticky underflow flag is raised. The repeat period is therefore one tick more than the constant.

Software reaches every register through a simple single-cycle register bus. Writes take effect at the next clock edge, and reads are combinational on the word address. Each channel drives an interrupt request line, which is its underflow flag gated by a per-channel interrupt-enable bit.

Top module: `tri_reload_timer`

## Requirements
- R1: After reset the start register reads 0, every count and constant register reads 32'hFFFF_FFFF, every control register reads 0 and all interrupt lines are low.
- R2: Control bits [2:0] pick the tick period in core clock cycles: 0 gives 16, 1 gives 64, 2 gives 256, 3 gives 1024 and 4 gives 4096. The first tick after a run bit is set moves the count at exactly that many clock edges after the edge that stored the run bit.
- R3: The select values 5, 6 and 7 behave as divide-by-16.
- R4: Start register bit n (word address 0) runs channel n only. While the bit is clear the count holds, and the prescaler restarts from zero, so the next run again waits a full period.
- R5: Each tick of a running channel lowers a non-zero count by exactly one.
- R6: A tick that finds the count at zero loads the constant register and sets control bit 8. With constant C the count repeats every C+1 ticks.
- R7: A control write with bit 8 equal to 0 clears the flag, and a write with bit 8 equal to 1 leaves the flag unchanged. If an underflow and a clearing write fall in the same cycle, the flag ends up set.
- R8: The interrupt line of channel n is high exactly when its flag (control bit 8) and its enable (control bit 5) are both 1.
- R9: A bus write to the count register in the same cycle as a tick stores the written value. The tick is lost and no underflow is taken.
- R10: Word addresses: 0 is the start register. Channel n uses 1+3n for control, 2+3n for count and 3+3n for constant. A control register reads back only bits [2:0], 5 and 8, with all other bits zero. Unmapped addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Write when high, together with bus_sel |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 3 | Per-channel interrupt request |

## Verification
Two pairs of events can meet in one clock edge. The first is a software write that clears a channel's flag, landing on the same edge as that channel's underflow. The second is a software write to the count register, landing on the same edge as a prescaled tick. The bench provokes each collision by starting the channel at a known edge and counting exactly sixteen edges, so that the bus write lands on the tick edge. It then judges the outcome through the read port: the flag must read set, and the count must hold the written value and only step down one full period later.

// File: rtl/trt_pkg.sv
package trt_pkg;
   localparam int SEL_W    = 3;
   localparam int PS_W     = 12;
   localparam int IE_BIT   = 5;
   localparam int FLAG_BIT = 8;

   // last prescaler count before a tick, reserved codes fall back to /16
   function automatic logic [PS_W-1:0] tick_last(input logic [SEL_W-1:0] sel);
      logic [PS_W-1:0] v;
      case (sel)
         3'd0:    v = PS_W'(15);
         3'd1:    v = PS_W'(63);
         3'd2:    v = PS_W'(255);
         3'd3:    v = PS_W'(1023);
         3'd4:    v = PS_W'(4095);
         default: v = PS_W'(15);
      endcase
      return v;
   endfunction
endpackage

// File: rtl/trt_decode.sv
module trt_decode #(
   parameter int NUM_CH = 3,
   parameter int ADDR_W = 4
) (
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              start_we,
   output logic [NUM_CH-1:0] ctrl_we,
   output logic [NUM_CH-1:0] cnt_we,
   output logic [NUM_CH-1:0] const_we
);
   logic wr_hit;
   assign wr_hit   = bus_sel && bus_wr;
   assign start_we = wr_hit && (bus_addr == '0);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(1 + 3*i);
      localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(2 + 3*i);
      localparam logic [ADDR_W-1:0] A_CONST = ADDR_W'(3 + 3*i);
      assign ctrl_we[i]  = wr_hit && (bus_addr == A_CTRL);
      assign cnt_we[i]   = wr_hit && (bus_addr == A_COUNT);
      assign const_we[i] = wr_hit && (bus_addr == A_CONST);
   end

   // R10: at most one register is written per access
   always_comb begin
      a_onehot_r10: assert ($onehot0({start_we, ctrl_we, cnt_we, const_we}))
         else $error("decode selected more than one register");
   end
endmodule

// File: rtl/trt_prescaler.sv
module trt_prescaler
   import trt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   logic [PS_W-1:0] pc_q;
   logic [PS_W-1:0] last;

   assign last = tick_last(sel);
   // >= keeps the period bounded when sel shrinks mid-count
   assign tick = run && (pc_q >= last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             pc_q <= '0;
      else if (!run || tick)  pc_q <= '0;
      else                    pc_q <= pc_q + 1'b1;
   end

   p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (pc_q == '0))
      else $error("prescaler did not restart while stopped");
endmodule

// File: rtl/trt_channel.sv
module trt_channel
   import trt_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ctrl_we,
   input  logic             cnt_we,
   input  logic             const_we,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] const_q,
   output logic [CNT_W-1:0] ctrl_rd,
   output logic [SEL_W-1:0] sel_q,
   output logic             irq
);
   logic ie_q;
   logic flag_q;
   logic uflow;

   assign uflow = tick && !cnt_we && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '1;
         const_q <= '1;
      end else begin
         if (const_we) const_q <= wdata;
         if (cnt_we)       cnt_q <= wdata;
         else if (uflow)   cnt_q <= const_q;
         else if (tick)    cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         ie_q   <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (ctrl_we) begin
            sel_q <= wdata[SEL_W-1:0];
            ie_q  <= wdata[IE_BIT];
         end
         if (uflow)                             flag_q <= 1'b1;
         else if (ctrl_we && !wdata[FLAG_BIT])  flag_q <= 1'b0;
      end
   end

   always_comb begin
      ctrl_rd               = '0;
      ctrl_rd[SEL_W-1:0]    = sel_q;
      ctrl_rd[IE_BIT]       = ie_q;
      ctrl_rd[FLAG_BIT]     = flag_q;
   end

   assign irq = flag_q && ie_q;

   p_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_we && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1))
      else $error("count did not step down");
   p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_we && cnt_q == '0) |=> (cnt_q == $past(const_q) && flag_q))
      else $error("underflow did not reload and flag");
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !cnt_we) |=> $stable(cnt_q))
      else $error("count moved without a tick");
   p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !(ctrl_we && !wdata[FLAG_BIT])) |=> flag_q)
      else $error("flag dropped without a clearing write");
   p_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_we |=> (cnt_q == $past(wdata)))
      else $error("count write lost");
endmodule

// File: rtl/tri_reload_timer.sv
module tri_reload_timer
   import trt_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic [NUM_CH-1:0] irq
);
   localparam int NUM_REGS = 1 + 3*NUM_CH;

   if (NUM_CH < 1 || NUM_CH > CNT_W) begin : g_bad_ch
      $error("NUM_CH out of range");
   end
   if (CNT_W <= FLAG_BIT) begin : g_bad_w
      $error("CNT_W too narrow for control fields");
   end
   if (NUM_REGS > (1 << ADDR_W)) begin : g_bad_a
      $error("ADDR_W too small for register map");
   end

   logic              start_we;
   logic [NUM_CH-1:0] ctrl_we, cnt_we, const_we;
   logic [NUM_CH-1:0] start_q;
   logic [NUM_CH-1:0] tick;
   logic [CNT_W-1:0]  cnt_v   [NUM_CH];
   logic [CNT_W-1:0]  const_v [NUM_CH];
   logic [CNT_W-1:0]  ctrl_v  [NUM_CH];
   logic [SEL_W-1:0]  sel_v   [NUM_CH];

   trt_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
      .bus_sel (bus_sel),
      .bus_wr  (bus_wr),
      .bus_addr(bus_addr),
      .start_we(start_we),
      .ctrl_we (ctrl_we),
      .cnt_we  (cnt_we),
      .const_we(const_we)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        start_q <= '0;
      else if (start_we) start_q <= bus_wdata[NUM_CH-1:0];
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      trt_prescaler u_ps (
         .clk  (clk),
         .rst_n(rst_n),
         .run  (start_q[i]),
         .sel  (sel_v[i]),
         .tick (tick[i])
      );
      trt_channel #(.CNT_W(CNT_W)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .tick    (tick[i]),
         .ctrl_we (ctrl_we[i]),
         .cnt_we  (cnt_we[i]),
         .const_we(const_we[i]),
         .wdata   (bus_wdata),
         .cnt_q   (cnt_v[i]),
         .const_q (const_v[i]),
         .ctrl_rd (ctrl_v[i]),
         .sel_q   (sel_v[i]),
         .irq     (irq[i])
      );

      p_irq_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (ctrl_we[i] && !bus_wdata[IE_BIT]) |=> !irq[i])
         else $error("interrupt high with enable cleared");
      p_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (!start_q[i] && !cnt_we[i]) |=> $stable(cnt_v[i]))
         else $error("stopped channel counted");
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == '0) bus_rdata[NUM_CH-1:0] = start_q;
      for (int i = 0; i < NUM_CH; i++) begin
         if (bus_addr == ADDR_W'(1 + 3*i)) bus_rdata = ctrl_v[i];
         if (bus_addr == ADDR_W'(2 + 3*i)) bus_rdata = cnt_v[i];
         if (bus_addr == ADDR_W'(3 + 3*i)) bus_rdata = const_v[i];
      end
   end
endmodule

// File: tb/tb_tri_reload_timer.sv
module tb_tri_reload_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [2:0]  irq;
   int n_run = 0, n_fail = 0;

   always #10 clk = ~clk;

   tri_reload_timer dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

   function automatic logic [3:0] a_ctrl(int ch);  return 4'(1 + 3*ch); endfunction
   function automatic logic [3:0] a_cnt(int ch);   return 4'(2 + 3*ch); endfunction
   function automatic logic [3:0] a_const(int ch); return 4'(3 + 3*ch); endfunction

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // called just after a falling edge; returns just after the next one
   task automatic wr(logic [3:0] a, logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(logic [3:0] a, output logic [31:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      do_reset();
      rd(4'd0, v);        check("R1 start", v, 32'h0);
      rd(a_cnt(0), v);    check("R1 count0", v, 32'hFFFF_FFFF);
      rd(a_const(1), v);  check("R1 const1", v, 32'hFFFF_FFFF);
      rd(a_ctrl(2), v);   check("R1 ctrl2", v, 32'h0);
      check("R1 irq", {29'd0, irq}, 32'h0);
   endtask

   task automatic t_prescale(int ch, int sel, int div, string req);
      logic [31:0] v;
      do_reset();
      wr(a_ctrl(ch), 32'(sel));
      wr(a_cnt(ch), 32'd1000);
      wr(4'd0, 32'(1 << ch));
      repeat (div - 1) @(negedge clk);
      rd(a_cnt(ch), v); check({req, " before tick"}, v, 32'd1000);
      @(negedge clk);
      rd(a_cnt(ch), v); check({req, " on tick"}, v, 32'd999);
   endtask

   task automatic t_reload();
      logic [31:0] v;
      do_reset();
      wr(a_const(0), 32'd2);
      wr(a_cnt(0), 32'd1);
      wr(4'd0, 32'd1);
      repeat (16) @(negedge clk);
      rd(a_cnt(0), v);  check("R5 step to zero", v, 32'd0);
      rd(a_ctrl(0), v); check("R6 no flag yet", v, 32'h0);
      repeat (16) @(negedge clk);
      rd(a_cnt(0), v);  check("R6 reload", v, 32'd2);
      rd(a_ctrl(0), v); check("R6 flag set", v, 32'h100);
      repeat (16) @(negedge clk);
      rd(a_cnt(0), v);  check("R5 step after reload", v, 32'd1);
      repeat (32) @(negedge clk);
      rd(a_cnt(0), v);  check("R6 period const+1", v, 32'd2);
   endtask

   task automatic t_irq();
      logic [31:0] v;
      do_reset();
      wr(a_cnt(0), 32'd0);
      wr(4'd0, 32'd1);
      repeat (16) @(negedge clk);
      rd(a_ctrl(0), v); check("R6 flag on underflow", v, 32'h100);
      check("R8 irq masked", {29'd0, irq}, 32'h0);
      wr(a_ctrl(0), 32'h120);
      rd(a_ctrl(0), v); check("R7 write 1 keeps flag", v, 32'h120);
      check("R8 irq raised", {29'd0, irq}, 32'h1);
      wr(a_ctrl(0), 32'h020);
      rd(a_ctrl(0), v); check("R7 write 0 clears", v, 32'h020);
      check("R8 irq dropped", {29'd0, irq}, 32'h0);
   endtask

   task automatic t_flag_collide();
      logic [31:0] v;
      do_reset();
      wr(a_cnt(0), 32'd0);
      wr(4'd0, 32'd1);
      repeat (15) @(negedge clk);
      wr(a_ctrl(0), 32'h0);   // lands on the underflow edge
      rd(a_ctrl(0), v); check("R7 set beats clear", v, 32'h100);
      rd(a_cnt(0), v);  check("R6 reload on collide", v, 32'hFFFF_FFFF);
      wr(a_ctrl(0), 32'h0);
      rd(a_ctrl(0), v); check("R7 later clear", v, 32'h0);
   endtask

   task automatic t_cnt_collide();
      logic [31:0] v;
      do_reset();
      wr(a_cnt(0), 32'd5);
      wr(4'd0, 32'd1);
      repeat (15) @(negedge clk);
      wr(a_cnt(0), 32'd100);  // lands on the tick edge
      rd(a_cnt(0), v); check("R9 write wins", v, 32'd100);
      repeat (15) @(negedge clk);
      rd(a_cnt(0), v); check("R9 next tick waits", v, 32'd100);
      @(negedge clk);
      rd(a_cnt(0), v); check("R9 next tick", v, 32'd99);
   endtask

   task automatic t_gate();
      logic [31:0] v;
      do_reset();
      wr(a_cnt(0), 32'd50);
      wr(4'd0, 32'd1);
      repeat (10) @(negedge clk);
      wr(4'd0, 32'd0);
      repeat (100) @(negedge clk);
      rd(a_cnt(0), v); check("R4 hold while stopped", v, 32'd50);
      wr(4'd0, 32'd1);
      repeat (15) @(negedge clk);
      rd(a_cnt(0), v); check("R4 prescaler restarted", v, 32'd50);
      @(negedge clk);
      rd(a_cnt(0), v); check("R4 full period after restart", v, 32'd49);
      rd(a_cnt(1), v); check("R4 other channel idle", v, 32'hFFFF_FFFF);
   endtask

   task automatic t_map();
      logic [31:0] v;
      do_reset();
      for (int a = 10; a < 16; a++) begin
         rd(4'(a), v); check("R10 unmapped reads 0", v, 32'h0);
      end
      wr(4'd12, 32'h1234_5678);
      rd(a_cnt(0), v);   check("R10 stray write count0", v, 32'hFFFF_FFFF);
      rd(a_const(2), v); check("R10 stray write const2", v, 32'hFFFF_FFFF);
      rd(4'd0, v);       check("R10 stray write start", v, 32'h0);
      wr(a_ctrl(1), 32'hFFFF_FFFF);
      rd(a_ctrl(1), v);  check("R10 ctrl field mask", v, 32'h027);
      wr(a_const(2), 32'hA5A5_0003);
      rd(a_const(2), v); check("R10 const2 address", v, 32'hA5A5_0003);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_prescale(0, 0, 16,   "R2 sel0");
      t_prescale(0, 1, 64,   "R2 sel1");
      t_prescale(1, 2, 256,  "R2 sel2");
      t_prescale(1, 3, 1024, "R2 sel3");
      t_prescale(2, 4, 4096, "R2 sel4");
      t_prescale(2, 5, 16,   "R3 sel5");
      t_prescale(0, 7, 16,   "R3 sel7");
      t_reload();
      t_irq();
      t_flag_collide();
      t_cnt_collide();
      t_gate();
      t_map();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule